// File: doc/BRIEF.md
# Programmable clock generator

This block derives one generated clock from a choice of free-running source clocks. Software programs it over a simple write port in the bus-clock domain. Each write sets the source index, the divide value, the divide mode, the duty-correction enable, the pin enable, the run-in-standby flag and the generator enable. Alternatively, a write can touch only the enable bit. Two divide modes exist. Binary mode treats the divide field as an exponent. Integer mode uses the field as the factor itself. Integer mode can optionally use both source edges to give odd factors an exact half-period high phase.

A written word is held in a shadow register and crosses into the generated-clock domain through a toggle request and acknowledge, each with a two-flop synchroniser. A busy output stays high from the write until the acknowledge has come back. While it is high, further writes are dropped. The generated-clock side holds a new setting as pending and applies it only at the end of the current output period, so a change never produces a truncated pulse. While the generator is stopped, its output is held low.

Top module: `gclk_gen`

## Requirements
- R1: After reset, `busy_o`, `gclk_o` and `pin_o` are low, and the output stays low until a write enables the generator.
- R2: A write (`wr_all_i` or `wr_en_i` high at a bus-clock edge while `busy_o` is low) raises `busy_o` at the next bus edge. `busy_o` falls by itself once the value has reached the generated-clock domain. Writes made while `busy_o` is high are ignored.
- R3: With the mode bit `wmode_i`=1 (binary), a divide field n gives a period of 2^(n+1) source periods with a 50% duty cycle. n=0 gives divide by 2; exponents of DIVW-1 or more saturate at 2^DIVW.
- R4: With `wmode_i`=0 (integer) and duty correction `widc_i`=0, a field N>1 gives a period of N source periods, high for floor(N/2) source periods.
- R5: In integer mode with `widc_i`=1 and odd N>1, the output is high for N source half-periods out of 2N. For even N, the output is the same as without correction.
- R6: In integer mode, a divide field of 0 or 1 passes the selected source clock straight through.
- R7: `wsrc_i` is the bit index into `src_clk_i` of the source that is divided.
- R8: `pin_o` follows `gclk_o` when the pin enable `woe_i` is 1 and is held low when it is 0.
- R9: While `standby_i` is high, the output stops low unless run-in-standby (`wrs_i`) is 1, in which case it keeps running.
- R10: A write with `wr_en_i` changes only the generator enable (`wgen_i`). Disabling stops the output low, and re-enabling restores the previously written divide settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus-side clock for writes and the busy flag |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| src_clk_i | input | NSRC | Candidate source clocks |
| standby_i | input | 1 | Standby request, synchronised in the generated domain |
| wr_all_i | input | 1 | Write strobe for every field |
| wr_en_i | input | 1 | Write strobe for the enable bit only |
| wsrc_i | input | SRCW | Source index to write |
| wdiv_i | input | DIVW | Divide field to write (exponent or factor) |
| wmode_i | input | 1 | Divide mode: 1 binary, 0 integer |
| widc_i | input | 1 | Duty correction for odd integer factors |
| woe_i | input | 1 | Drive the generated clock onto `pin_o` |
| wrs_i | input | 1 | Keep running during standby |
| wgen_i | input | 1 | Generator enable |
| busy_o | output | 1 | Write in flight to the generated domain |
| gclk_o | output | 1 | Generated clock |
| pin_o | output | 1 | Generated clock gated by the pin enable |

## Verification
The hardest condition to create from the ports is a second write that reaches the block while the first is still crossing domains. That write must be dropped, and the output must then settle on the first setting. The bench issues two full writes two bus cycles apart on a fast source, where the round trip of the handshake lasts several bus cycles, and then measures the resulting output period. Duty correction is observed by timestamping both output edges with sub-nanosecond polling, so that a half source period of extension can be told apart from a whole one.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;

    // Encoding of the divide-mode bit
    typedef enum logic {
        DIVMODE_INT = 1'b0,
        DIVMODE_BIN = 1'b1
    } divmode_e;

endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
module gclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[N-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign q_o = sr_q[N-1];
endmodule

// File: rtl/gclk_bus_side.sv
`timescale 1ns/1ps
module gclk_bus_side
    import gclk_pkg::*;
#(
    parameter int SRCW = 1,
    parameter int DIVW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_all_i,
    input  logic            wr_en_i,
    input  logic [SRCW-1:0] src_i,
    input  logic [DIVW-1:0] div_i,
    input  divmode_e        mode_i,
    input  logic            idc_i,
    input  logic            oe_i,
    input  logic            rs_i,
    input  logic            en_i,
    input  logic            ack_i,
    output logic [SRCW-1:0] src_o,
    output logic [DIVW-1:0] div_o,
    output divmode_e        mode_o,
    output logic            idc_o,
    output logic            oe_o,
    output logic            rs_o,
    output logic            en_o,
    output logic            req_o,
    output logic            busy_o
);
    typedef struct packed {
        logic [SRCW-1:0] src;
        logic [DIVW-1:0] div;
        divmode_e        mode;
        logic            idc;
        logic            oe;
        logic            rs;
        logic            en;
        logic            req;
    } shadow_t;

    shadow_t s_d, s_q;
    logic    busy;

    always_comb begin
        s_d  = s_q;
        busy = (s_q.req != ack_i);
        if ((wr_all_i || wr_en_i) && !busy) begin
            if (wr_all_i) begin
                s_d.src  = src_i;
                s_d.div  = div_i;
                s_d.mode = mode_i;
                s_d.idc  = idc_i;
                s_d.oe   = oe_i;
                s_d.rs   = rs_i;
            end
            s_d.en  = en_i;
            s_d.req = ~s_q.req;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign src_o  = s_q.src;
    assign div_o  = s_q.div;
    assign mode_o = s_q.mode;
    assign idc_o  = s_q.idc;
    assign oe_o   = s_q.oe;
    assign rs_o   = s_q.rs;
    assign en_o   = s_q.en;
    assign req_o  = s_q.req;
    assign busy_o = busy;
endmodule

// File: rtl/gclk_core.sv
`timescale 1ns/1ps
module gclk_core
    import gclk_pkg::*;
#(
    parameter int DIVW = 8,
    parameter int SYNC = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    input  logic            standby_i,
    input  logic [DIVW-1:0] div_i,
    input  divmode_e        mode_i,
    input  logic            idc_i,
    input  logic            oe_i,
    input  logic            rs_i,
    input  logic            en_i,
    output logic            ack_o,
    output logic            clk_out_o,
    output logic            oe_o
);
    localparam int FW = DIVW + 1;

    typedef struct packed {
        logic [DIVW-1:0] div;
        divmode_e        mode;
        logic            idc;
        logic            oe;
        logic            rs;
        logic            en;
    } gcfg_t;

    typedef struct packed {
        gcfg_t         act;
        gcfg_t         pend;
        logic          pend_v;
        logic          ack;
        logic          run;
        logic [FW-1:0] cnt;
        logic          hi;
    } core_t;

    function automatic logic [FW-1:0] fac_of(gcfg_t c);
        logic [FW-1:0] f;
        if (c.mode == DIVMODE_BIN) begin
            if (int'(c.div) >= DIVW - 1) f = FW'(1) << DIVW;
            else                         f = FW'(1) << (int'(c.div) + 1);
        end else begin
            f = FW'(c.div);
        end
        return f;
    endfunction

    core_t         s_d, s_q;
    gcfg_t         in_cfg, nact;
    logic          req_s, stby_s;
    logic          bnd, cap, odd_fix;
    logic [FW-1:0] fac_q, fac_n, half_n;
    logic          ext_q, byp_q;

    assign in_cfg = '{div: div_i, mode: mode_i, idc: idc_i, oe: oe_i, rs: rs_i, en: en_i};

    gclk_sync #(.STAGES(SYNC)) u_req_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_s)
    );
    gclk_sync #(.STAGES(SYNC)) u_stby_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(standby_i), .q_o(stby_s)
    );

    always_comb begin
        s_d   = s_q;
        nact  = s_q.act;
        fac_q = fac_of(s_q.act);
        bnd   = !s_q.run || (fac_q <= FW'(1)) || (s_q.cnt == fac_q - FW'(1));
        cap   = (req_s != s_q.ack);
        // capture a newly arrived control word and acknowledge it
        if (cap) begin
            s_d.pend   = in_cfg;
            s_d.pend_v = 1'b1;
            s_d.ack    = req_s;
        end
        // settings change only at the end of an output period
        if (bnd) begin
            if (s_q.pend_v) nact = s_q.pend;
            if (!cap) s_d.pend_v = 1'b0;
            s_d.act = nact;
            s_d.run = nact.en && !(stby_s && !nact.rs);
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + FW'(1);
        end
        fac_n   = fac_of(s_d.act);
        half_n  = fac_n >> 1;
        s_d.hi  = s_d.run && (fac_n > FW'(1)) && (s_d.cnt < half_n);
        odd_fix = (s_q.act.mode == DIVMODE_INT) && s_q.act.idc && fac_q[0] && (fac_q > FW'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // falling-edge stage: half-period extension and pass-through gate
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ext_q <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            ext_q <= s_q.hi && odd_fix;
            byp_q <= s_q.run && (fac_q <= FW'(1));
        end
    end

    assign clk_out_o = (clk_i & byp_q) | s_q.hi | ext_q;
    assign oe_o      = s_q.act.oe;
    assign ack_o     = s_q.ack;
endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
    import gclk_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int DIVW = 8,
    parameter int SYNC = 2,
    localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            bus_clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_clk_i,
    input  logic            standby_i,
    input  logic            wr_all_i,
    input  logic            wr_en_i,
    input  logic [SRCW-1:0] wsrc_i,
    input  logic [DIVW-1:0] wdiv_i,
    input  logic            wmode_i,
    input  logic            widc_i,
    input  logic            woe_i,
    input  logic            wrs_i,
    input  logic            wgen_i,
    output logic            busy_o,
    output logic            gclk_o,
    output logic            pin_o
);
    localparam int SHW = SRCW + DIVW + 5;

    logic [SRCW-1:0] sh_src;
    logic [DIVW-1:0] sh_div;
    divmode_e        sh_mode;
    logic            sh_idc, sh_oe, sh_rs, sh_en;
    logic            req, ack_gen, ack_bus;
    logic            gen_clk, core_oe;
    logic [SHW-1:0]  sh_word;

    gclk_bus_side #(.SRCW(SRCW), .DIVW(DIVW)) u_bus (
        .clk_i   (bus_clk_i),
        .rst_ni  (rst_ni),
        .wr_all_i(wr_all_i),
        .wr_en_i (wr_en_i),
        .src_i   (wsrc_i),
        .div_i   (wdiv_i),
        .mode_i  (divmode_e'(wmode_i)),
        .idc_i   (widc_i),
        .oe_i    (woe_i),
        .rs_i    (wrs_i),
        .en_i    (wgen_i),
        .ack_i   (ack_bus),
        .src_o   (sh_src),
        .div_o   (sh_div),
        .mode_o  (sh_mode),
        .idc_o   (sh_idc),
        .oe_o    (sh_oe),
        .rs_o    (sh_rs),
        .en_o    (sh_en),
        .req_o   (req),
        .busy_o  (busy_o)
    );

    gclk_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk_i(bus_clk_i), .rst_ni(rst_ni), .d_i(ack_gen), .q_o(ack_bus)
    );

    // source selection follows the shadow register
    generate
        if ((1 << SRCW) == NSRC) begin : g_src_pow2
            assign gen_clk = src_clk_i[sh_src];
        end else begin : g_src_any
            assign gen_clk = (int'(sh_src) < NSRC) ? src_clk_i[sh_src] : src_clk_i[0];
        end
    endgenerate

    gclk_core #(.DIVW(DIVW), .SYNC(SYNC)) u_core (
        .clk_i    (gen_clk),
        .rst_ni   (rst_ni),
        .req_i    (req),
        .standby_i(standby_i),
        .div_i    (sh_div),
        .mode_i   (sh_mode),
        .idc_i    (sh_idc),
        .oe_i     (sh_oe),
        .rs_i     (sh_rs),
        .en_i     (sh_en),
        .ack_o    (ack_gen),
        .clk_out_o(gclk_o),
        .oe_o     (core_oe)
    );

    assign pin_o   = gclk_o & core_oe;
    assign sh_word = {sh_src, sh_div, sh_mode, sh_idc, sh_oe, sh_rs, sh_en};
endmodule

module gclk_gen_chk #(
    parameter int W = 14
) (
    input logic         bus_clk_i,
    input logic         rst_ni,
    input logic         wr_all_i,
    input logic         wr_en_i,
    input logic         busy_o,
    input logic         gclk_o,
    input logic         pin_o,
    input logic [W-1:0] sh_word
);
    p_busy_after_write_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
        (wr_all_i || wr_en_i) && !busy_o |=> busy_o);

    p_busy_from_write_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(wr_all_i || wr_en_i));

    p_shadow_held_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(sh_word));

    p_pin_needs_clk_r8: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
        pin_o |-> gclk_o);
endmodule

bind gclk_gen gclk_gen_chk #(.W(SHW)) u_chk (
    .bus_clk_i(bus_clk_i),
    .rst_ni   (rst_ni),
    .wr_all_i (wr_all_i),
    .wr_en_i  (wr_en_i),
    .busy_o   (busy_o),
    .gclk_o   (gclk_o),
    .pin_o    (pin_o),
    .sh_word  (sh_word)
);

// File: tb/test_gclk_gen.sv
`timescale 1ns/1ps
module test_gclk_gen;
    logic       bus_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] src_clk = 2'b00;
    logic       stby    = 1'b0;
    logic       wr_all = 1'b0, wr_en = 1'b0;
    logic [0:0] wsrc = '0;
    logic [7:0] wdiv = '0;
    logic       wmode = 1'b0, widc = 1'b0, woe = 1'b0, wrs = 1'b0, wgen = 1'b0;
    logic       busy, gclk, pin;

    always #10 bus_clk    = ~bus_clk;   // 50 MHz
    always #5  src_clk[0] = ~src_clk[0]; // 10 ns source
    always #7  src_clk[1] = ~src_clk[1]; // 14 ns source

    gclk_gen #(.NSRC(2), .DIVW(8), .SYNC(2)) i_gclk_gen (
        .bus_clk_i(bus_clk), .rst_ni(rst_n), .src_clk_i(src_clk), .standby_i(stby),
        .wr_all_i(wr_all), .wr_en_i(wr_en), .wsrc_i(wsrc), .wdiv_i(wdiv),
        .wmode_i(wmode), .widc_i(widc), .woe_i(woe), .wrs_i(wrs), .wgen_i(wgen),
        .busy_o(busy), .gclk_o(gclk), .pin_o(pin)
    );

    typedef struct {
        real   per;
        real   hi;
        bit    run;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_busy = 1'b0;
    int   n_chk = 0;
    int   n_err = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input real act, input real expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wait_lvl(input logic lvl, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (gclk === lvl) begin
                ok = 1'b1;
                break;
            end
            #0.1;
        end
    endtask

    // monitor: pops expectations and measures the generated clock
    initial begin
        exp_t it;
        bit   ok, seen;
        real  t0, t1, t2;
        forever begin
            wait (exp_q.size() > 0);
            mon_busy = 1'b1;
            it = exp_q.pop_front();
            #150.05;
            if (it.run) begin
                ok = 1'b1;
                for (int k = 0; k < 2; k++) begin
                    bit a, b;
                    wait_lvl(1'b0, a);
                    wait_lvl(1'b1, b);
                    ok = ok & a & b;
                end
                t0 = $realtime;
                begin
                    bit a, b;
                    wait_lvl(1'b0, a);
                    t1 = $realtime;
                    wait_lvl(1'b1, b);
                    t2 = $realtime;
                    ok = ok & a & b;
                end
                check(ok, it.tag, "output toggles", ok, 1);
                check(ok && ((t2 - t0) > it.per - 0.25) && ((t2 - t0) < it.per + 0.25),
                      it.tag, "period ns", t2 - t0, it.per);
                check(ok && ((t1 - t0) > it.hi - 0.25) && ((t1 - t0) < it.hi + 0.25),
                      it.tag, "high time ns", t1 - t0, it.hi);
            end else begin
                seen = 1'b0;
                for (int i = 0; i < 3000; i++) begin
                    if (gclk !== 1'b0) seen = 1'b1;
                    #0.1;
                end
                check(!seen, it.tag, "output held low", seen, 0);
            end
            mon_busy = 1'b0;
        end
    end

    // driver side
    task automatic do_write(input bit all, input logic s, input logic [7:0] d,
                            input logic m, input logic i, input logic o,
                            input logic r, input logic g, input string tag);
        @(negedge bus_clk);
        wr_all = all; wr_en = !all;
        wsrc = s; wdiv = d; wmode = m; widc = i; woe = o; wrs = r; wgen = g;
        @(negedge bus_clk);
        wr_all = 1'b0; wr_en = 1'b0;
        check(busy === 1'b1, tag, "busy after write (R2)", busy, 1);
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy !== 1'b0 && n < 200) begin
            @(negedge bus_clk);
            n++;
        end
        check(busy === 1'b0, tag, "busy clears (R2)", busy, 0);
    endtask

    task automatic expect_clk(input real per, input real hi, input bit run, input string tag);
        exp_t e;
        e.per = per; e.hi = hi; e.run = run; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0 && mon_busy == 1'b0);
    endtask

    task automatic set_run(input logic s, input logic [7:0] d, input logic m,
                           input logic i, input logic o, input logic r,
                           input real per, input real hi, input string tag);
        do_write(1'b1, s, d, m, i, o, r, 1'b1, tag);
        wait_idle(tag);
        expect_clk(per, hi, 1'b1, tag);
    endtask

    initial begin
        #1;
        repeat (3) @(negedge bus_clk);
        check(busy === 1'b0 && gclk === 1'b0 && pin === 1'b0, "R1", "outputs in reset",
              {busy, gclk, pin}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        expect_clk(0, 0, 1'b0, "R1");

        // binary mode (R3) and source select (R7)
        set_run(1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0, 20.0, 10.0, "R3");
        set_run(1'b0, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 40.0, 20.0, "R3");
        set_run(1'b1, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 112.0, 56.0, "R7");

        // integer mode without correction (R4)
        set_run(1'b0, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 30.0, 10.0, "R4");
        set_run(1'b0, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 50.0, 20.0, "R4");

        // integer mode with correction (R5)
        set_run(1'b0, 8'd3, 1'b0, 1'b1, 1'b1, 1'b0, 30.0, 15.0, "R5");
        set_run(1'b0, 8'd5, 1'b0, 1'b1, 1'b1, 1'b0, 50.0, 25.0, "R5");
        set_run(1'b0, 8'd6, 1'b0, 1'b1, 1'b1, 1'b0, 60.0, 30.0, "R5");
        set_run(1'b1, 8'd5, 1'b0, 1'b1, 1'b1, 1'b0, 70.0, 35.0, "R7");

        // pass-through (R6)
        set_run(1'b0, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 10.0, 5.0, "R6");
        set_run(1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 10.0, 5.0, "R6");

        // pin enable (R8)
        set_run(1'b0, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 40.0, 20.0, "R8");
        begin
            bit pin_hi, clk_hi;
            pin_hi = 1'b0; clk_hi = 1'b0;
            #0.05;
            for (int i = 0; i < 2000; i++) begin
                if (pin !== 1'b0) pin_hi = 1'b1;
                if (gclk === 1'b1) clk_hi = 1'b1;
                #0.1;
            end
            check(!pin_hi && clk_hi, "R8", "pin low while clock runs", pin_hi, 0);
        end
        set_run(1'b0, 8'd4, 1'b0, 1'b0, 1'b1, 1'b0, 40.0, 20.0, "R8");
        begin
            bit diff, pin_hi;
            diff = 1'b0; pin_hi = 1'b0;
            #0.05;
            for (int i = 0; i < 2000; i++) begin
                if (pin !== gclk) diff = 1'b1;
                if (pin === 1'b1) pin_hi = 1'b1;
                #0.1;
            end
            check(!diff && pin_hi, "R8", "pin follows clock", diff, 0);
        end

        // standby (R9)
        stby = 1'b1;
        expect_clk(0, 0, 1'b0, "R9");
        stby = 1'b0;
        expect_clk(40.0, 20.0, 1'b1, "R9");
        set_run(1'b0, 8'd4, 1'b0, 1'b0, 1'b1, 1'b1, 40.0, 20.0, "R9");
        stby = 1'b1;
        expect_clk(40.0, 20.0, 1'b1, "R9");
        stby = 1'b0;

        // enable-only writes (R10)
        set_run(1'b0, 8'd6, 1'b0, 1'b0, 1'b1, 1'b0, 60.0, 30.0, "R10");
        do_write(1'b0, 1'b1, 8'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        wait_idle("R10");
        expect_clk(0, 0, 1'b0, "R10");
        do_write(1'b0, 1'b1, 8'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        wait_idle("R10");
        expect_clk(60.0, 30.0, 1'b1, "R10");

        // second write while busy is dropped (R2)
        do_write(1'b1, 1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        do_write(1'b1, 1'b0, 8'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        wait_idle("R2");
        expect_clk(20.0, 10.0, 1'b1, "R2");

        summary();
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        summary();
    end
endmodule